// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

The block sends asynchronous serial frames on one output line. The host writes a word into a one-entry holding register. As soon as the transmit shift register is free, the word moves into it, and the line starts on the next baud tick. Because the holding register empties again at that transfer, the host can queue the next word while the current frame is still on the line. The shifter then chains the two frames with no idle time between them.

Each frame is a low start bit, the data bits least-significant first, an optional ninth bit and a high stop bit. When the ninth bit is enabled, its value comes from a control input and not from the written word. An internal baud generator divides the system clock by a ratio set by an 8-bit divisor and a high-speed select. Two flags report the state of the two stages: one for the holding register and one for the shifter. An interrupt request follows the holding-register flag, gated by an enable input.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, tx_o is 1, hold_empty is 1 and shift_empty is 1.
- R2: A frame is one start bit of 0, then the DATA_W data bits with bit 0 first, then one stop bit of 1. Each bit stays on tx_o for exactly one bit period P.
- R3: The bit period P is 16*(N+1) clock cycles when hs_sel is 1 and 64*(N+1) when hs_sel is 0, where N is the value on divisor.
- R4: A write (wr_en high with tx_en high) clears hold_empty on the next cycle. If the shifter is idle, the word moves to it one cycle after that: hold_empty returns to 1 and shift_empty goes to 0. The start bit begins on the following baud tick.
- R5: If a word is waiting in the holding register when a stop bit ends, the start bit of that word begins exactly in the cycle the stop bit ends. The start of the next frame is therefore exactly the frame length times P after the start of the previous frame.
- R6: shift_empty stays 0 while a frame is on the line, including its stop bit. It rises only after the stop bit of the last queued word has ended.
- R7: With nine_en at 1, a ninth bit holding the value of nine_bit follows the data bits, for an 11-bit frame. With nine_en at 0, the frame is 10 bits and nine_bit has no effect.
- R8: irq equals hold_empty AND irq_en at all times.
- R9: A write while the holding register is already full replaces the pending word. Only the latest word is sent.
- R10: While tx_en is 0, any frame in progress is aborted. After one cycle, tx_o is 1, hold_empty is 1 and shift_empty is 1. Writes made while tx_en is 0 are ignored, and no frame follows when tx_en returns to 1.
- R11: If a write falls in the same cycle as the transfer from the holding register to the shifter, the older word goes to the shifter and the new word stays in the holding register. In that case hold_empty stays 0.
- R12: While tx_en is 1, tx_o changes value only in the cycle right after a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to transmit |
| tx_en | input | 1 | Transmit enable; low aborts and empties both stages |
| nine_en | input | 1 | Send a ninth bit after the data |
| nine_bit | input | 1 | Value of the ninth bit |
| hs_sel | input | 1 | High-speed divide ratio select (16 instead of 64) |
| divisor | input | DIV_W | Baud divisor N |
| irq_en | input | 1 | Interrupt enable |
| tx_o | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Shifter is idle |
| irq | output | 1 | Holding-register-empty interrupt request |

## Verification
Two events can meet in one clock edge: a host write into the holding register, and the transfer of the previous word into the shifter. The bench provokes this by writing a first word while the shifter is idle and a second word on the very next cycle, which is the cycle in which the first word is taken. It then checks that hold_empty stays low, that the first word is sent first, and that the second word follows with no gap. The same scoreboard also covers the case where a write meets a full holding register, which must overwrite it, and the case where an end-of-stop tick meets a pending word, which must chain the two frames with no gap.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  // start + stop + optional ninth bit around the data
  localparam int unsigned FRAME_EXTRA = 3;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sh_state_e;
endpackage

// File: rtl/dbt_baud_gen.sv
module dbt_baud_gen #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned HS_MUL = 16,
  parameter int unsigned LS_MUL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hs_sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int unsigned CNT_W = DIV_W + $clog2(LS_MUL) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last, mul_w;
  logic             tick_q, tick_d;

  always_comb begin
    mul_w = hs_sel ? CNT_W'(HS_MUL) : CNT_W'(LS_MUL);
    last  = CNT_W'((CNT_W'(div) + CNT_W'(1)) * mul_w - CNT_W'(1));
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q >= last) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R3: a tick is a single-cycle pulse
  a_r3_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dbt_hold_stage.sv
module dbt_hold_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_ce;

  always_comb begin
    data_ce = en && wr;
    data_d  = wr_data;
    full_d  = full_q;
    if (!en)        full_d = 1'b0;
    else if (wr)    full_d = 1'b1;
    else if (take)  full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_ce) data_q <= data_d;
  end

  assign full = full_q;
  assign data = data_q;

  // R4 / R9 / R11: a write always leaves a word resident
  a_r11_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr) |=> full);
  // R4: a transfer without a new write empties the register
  a_r4_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (en && take && !wr) |=> !full);
endmodule

// File: rtl/dbt_shift_stage.sv
module dbt_shift_stage
  import dbt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              nine_en,
  input  logic              nine_bit,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              idle,
  output logic              txd
);
  localparam int unsigned FRM_W = DATA_W + FRAME_EXTRA;
  localparam int unsigned LEN_W = $clog2(FRM_W + 1);

  sh_state_e        st_q, st_d;
  logic [FRM_W-1:0] sr_q, sr_d, frame;
  logic [LEN_W-1:0] left_q, left_d, flen;
  logic             txd_q, txd_d;
  logic             last_done;

  always_comb begin
    frame     = {1'b1, (nine_en ? nine_bit : 1'b1), hold_data, 1'b0};
    flen      = nine_en ? LEN_W'(FRM_W) : LEN_W'(FRM_W - 1);
    last_done = (st_q == ST_BUSY) && tick && (left_q == '0);
    take      = en && hold_full && ((st_q == ST_IDLE) || last_done);

    st_d   = st_q;
    sr_d   = sr_q;
    left_d = left_q;
    txd_d  = txd_q;
    if (!en) begin
      st_d   = ST_IDLE;
      sr_d   = '1;
      left_d = '0;
      txd_d  = 1'b1;
    end else if (st_q == ST_IDLE) begin
      if (take) begin
        st_d   = ST_BUSY;
        sr_d   = frame;
        left_d = flen;
      end
    end else if (tick) begin
      if (left_q != '0) begin
        txd_d  = sr_q[0];
        sr_d   = {1'b1, sr_q[FRM_W-1:1]};
        left_d = left_q - LEN_W'(1);
      end else if (take) begin
        txd_d  = frame[0];
        sr_d   = {1'b1, frame[FRM_W-1:1]};
        left_d = flen - LEN_W'(1);
      end else begin
        st_d  = ST_IDLE;
        txd_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sr_q   <= '1;
      left_q <= '0;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      left_q <= left_d;
      txd_q  <= txd_d;
    end
  end

  assign idle = (st_q == ST_IDLE);
  assign txd  = txd_q;

  // R12: line moves only on a baud tick while enabled
  a_r12_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(txd));
  // R6: an idle shifter leaves the line high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> txd);
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned HS_MUL = 16,
  parameter int unsigned LS_MUL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              nine_en,
  input  logic              nine_bit,
  input  logic              hs_sel,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              irq_en,
  output logic              tx_o,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);
  logic              tick, take, full, idle, txd;
  logic [DATA_W-1:0] hdata;

  dbt_baud_gen #(.DIV_W(DIV_W), .HS_MUL(HS_MUL), .LS_MUL(LS_MUL)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .hs_sel(hs_sel),
    .div(divisor), .tick(tick)
  );

  dbt_hold_stage #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .wr(wr_en), .wr_data(wr_data),
    .take(take), .full(full), .data(hdata)
  );

  dbt_shift_stage #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tick),
    .nine_en(nine_en), .nine_bit(nine_bit),
    .hold_full(full), .hold_data(hdata),
    .take(take), .idle(idle), .txd(txd)
  );

  assign tx_o        = txd;
  assign hold_empty  = !full;
  assign shift_empty = idle;
  assign irq         = hold_empty && irq_en;

  // R10: disable empties both stages and parks the line
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (tx_o && hold_empty && shift_empty));
  // R4: a waiting word never sits beside an idle shifter
  a_r4_prompt_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !hold_empty && shift_empty) |=> !shift_empty);
endmodule

// File: tb/dbuf_uart_tx_tb_top.sv
`timescale 1ns/1ps
module dbuf_uart_tx_tb_top;
  typedef struct {
    logic [7:0] d;
    bit         nine;
    bit         nb;
    bit         gap;
  } exp_t;

  logic       clk, rst_n, wr_en, tx_en, nine_en, nine_bit, hs_sel, irq_en;
  logic [7:0] wr_data, divisor;
  logic       tx_o, hold_empty, shift_empty, irq;

  int   total = 0, bad = 0, cyc = 0, bit_p = 16;
  bit   mon_on = 1'b1, mon_busy = 1'b0, finished = 1'b0;
  exp_t q[$];
  int   last_t0 = 0, last_len = 0;

  dbuf_uart_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_en(tx_en), .nine_en(nine_en), .nine_bit(nine_bit), .hs_sel(hs_sel),
    .divisor(divisor), .irq_en(irq_en), .tx_o(tx_o),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic set_baud(input logic hs, input logic [7:0] n);
    hs_sel  = hs;
    divisor = n;
    bit_p   = (int'(n) + 1) * (hs ? 16 : 64);
  endtask

  // push expectation and pulse a write, no waiting for space
  task automatic raw_write(input logic [7:0] d, input bit gap, input bit replace);
    exp_t e;
    e.d = d; e.nine = nine_en; e.nb = nine_bit; e.gap = gap;
    if (replace) void'(q.pop_back());
    q.push_back(e);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    while (!hold_empty) @(negedge clk);
    raw_write(d, !shift_empty, 1'b0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0 || mon_busy || !shift_empty || !hold_empty)
      @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_frame();
    exp_t e;
    int   t0, len;
    logic [7:0] got;
    t0 = cyc;
    mon_busy = 1'b1;
    if (q.size() == 0) begin
      chk(1'b0, "R2 unexpected frame", 1, 0);
      repeat (bit_p) @(negedge clk);
      mon_busy = 1'b0;
      return;
    end
    e   = q.pop_front();
    len = e.nine ? 11 : 10;
    if (e.gap) chk(t0 == last_t0 + last_len * bit_p, "R5 gapless start", t0, last_t0 + last_len * bit_p);
    repeat (bit_p / 2) @(negedge clk);
    chk(tx_o == 1'b0, "R2 start bit", tx_o, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bit_p) @(negedge clk);
      got[i] = tx_o;
    end
    chk(got == e.d, "R2 R3 data bits", got, e.d);
    if (e.nine) begin
      repeat (bit_p) @(negedge clk);
      chk(tx_o == e.nb, "R7 ninth bit", tx_o, e.nb);
    end
    repeat (bit_p) @(negedge clk);
    chk(tx_o == 1'b1, "R2 R7 stop bit", tx_o, 1);
    last_t0  = t0;
    last_len = len;
    if (q.size() == 0 && hold_empty) begin
      chk(shift_empty == 1'b0, "R6 busy during stop", shift_empty, 0);
      repeat (bit_p / 2 + 2) @(negedge clk);
      chk(shift_empty == 1'b1, "R6 empty after stop", shift_empty, 1);
    end
    mon_busy = 1'b0;
  endtask

  // monitor: pops expectations as frames appear on the line
  initial begin
    logic prev_tx;
    prev_tx = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && mon_on && prev_tx && !tx_o) rx_frame();
      prev_tx = tx_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tx_en = 1'b0;
    nine_en = 1'b0; nine_bit = 1'b0; irq_en = 1'b0;
    set_baud(1'b1, 8'd0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_o == 1'b1, "R1 tx idle", tx_o, 1);
    chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    chk(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    tx_en  = 1'b1;
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq enabled", irq, 1);

    // R4 write then transfer, single word
    raw_write(8'hA5, 1'b0, 1'b0);
    chk(hold_empty == 1'b0, "R4 hold cleared", hold_empty, 0);
    chk(irq == 1'b0, "R8 irq low", irq, 0);
    chk(shift_empty == 1'b1, "R4 not yet loaded", shift_empty, 1);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R4 hold refilled", hold_empty, 1);
    chk(shift_empty == 1'b0, "R4 shifter loaded", shift_empty, 0);
    chk(irq == 1'b1, "R8 irq follows", irq, 1);
    wait_idle();

    // R5 back to back
    send(8'h3C); send(8'hC3); send(8'h00); send(8'hFF);
    wait_idle();

    // R11 write in the transfer cycle
    raw_write(8'h12, 1'b0, 1'b0);
    raw_write(8'h34, 1'b1, 1'b0);
    chk(hold_empty == 1'b0, "R11 new word kept", hold_empty, 0);
    chk(shift_empty == 1'b0, "R11 old word shifting", shift_empty, 0);
    wait_idle();

    // R9 overwrite of a pending word
    raw_write(8'h81, 1'b0, 1'b0);
    @(negedge clk);
    raw_write(8'h22, 1'b1, 1'b0);
    raw_write(8'h7E, 1'b1, 1'b1);
    wait_idle();

    // R7 nine-bit frames, both ninth values
    nine_en = 1'b1; nine_bit = 1'b1;
    send(8'h5A);
    wait_idle();
    nine_bit = 1'b0;
    send(8'hE7); send(8'h18);
    wait_idle();
    nine_en = 1'b0; nine_bit = 1'b1;
    send(8'h69);
    wait_idle();
    nine_bit = 1'b0;

    // R3 low-speed ratio and another divisor
    set_baud(1'b0, 8'd2);
    send(8'h96); send(8'h0F);
    wait_idle();
    set_baud(1'b1, 8'd3);
    send(8'hB4);
    wait_idle();
    set_baud(1'b1, 8'd0);

    // R10 abort mid-frame with a word pending
    mon_on = 1'b0;
    raw_write(8'h55, 1'b0, 1'b0);
    @(negedge clk);
    raw_write(8'hAA, 1'b1, 1'b0);
    q.delete();
    while (tx_o) @(negedge clk);
    repeat (3) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(tx_o == 1'b1, "R10 line high", tx_o, 1);
    chk(hold_empty == 1'b1, "R10 hold emptied", hold_empty, 1);
    chk(shift_empty == 1'b1, "R10 shifter emptied", shift_empty, 1);
    wr_data = 8'h0F;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    chk(hold_empty == 1'b1, "R10 write ignored", hold_empty, 1);
    tx_en  = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
    chk(shift_empty == 1'b1, "R10 nothing loaded", shift_empty, 1);
    repeat (3 * bit_p) begin
      @(negedge clk);
      if (tx_o !== 1'b1) begin
        chk(1'b0, "R10 line stayed high", tx_o, 1);
        break;
      end
    end
    chk(hold_empty == 1'b1 && shift_empty == 1'b1, "R10 still idle",
        {hold_empty, shift_empty}, 3);

    // recovery after abort
    send(8'hC9);
    wait_idle();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule